// File: doc/BRIEF.md
# I2S Balanced Channel Splitter

This block accepts one stereo I2S stream and produces two I2S streams, each intended for its own mono converter in a balanced output stage. Stream A carries the left sample in its left slot and the inverted left sample in its right slot. Stream B does the same for the right sample. Each converter therefore handles both polarities of a single channel. It does not handle one polarity of both channels.

Every 16-bit input sample is deserialised on the rising bit-clock edge. The inverted copy is formed by one of two static negation methods. The first is exact two's-complement negation, which saturates the single code that has no positive counterpart. The second is plain bit inversion, which costs one LSB of negative offset. The resulting frame is reserialised on the incoming bit clock with a regenerated word select. A second static input chooses 16-bit slots (32 bit clocks per frame, which is 1.4112 MHz at 44.1 kHz) or 32-bit slots. In the 32-bit case each value is sign-filled in its low half after negation.

Top module: `i2s_balanced_split`

## Requirements
- R1: Stream A (`sda_o`) carries the left input sample in its left slot (word select low) and the inverted left sample in its right slot. Stream B (`sdb_o`) carries the right input sample and its inverted copy in the same slot order.
- R2: With `exact_neg_i` low, the inverted copy is the bitwise complement of the sample (equal to -x-1). For example 0x0000 becomes 0xFFFF, 0x0001 becomes 0xFFFE, 0x7FFF becomes 0x8000 and 0x8000 becomes 0x7FFF.
- R3: With `exact_neg_i` high, the inverted copy is the complement plus one. For example 0x0000 stays 0x0000, 0x0001 becomes 0xFFFF, 0xFFFF becomes 0x0001 and 0x7FFF becomes 0x8001.
- R4: With `exact_neg_i` high, the input 0x8000 produces an inverted copy of 0x7FFF (saturation).
- R5: With `wide_slot_i` high, each output slot is 32 bits long. It carries the 16-bit value MSB first, followed by 16 copies of that value's sign bit. The fill is taken after negation, separately for each slot.
- R6: An output frame lasts twice the slot width in bit clocks: 32 bit clocks with `wide_slot_i` low (16-bit slots), 64 with it high.
- R7: Output framing is I2S. `ws_o` equals `ws_i` as sampled two rising bit-clock edges earlier. Each slot's MSB follows its `ws_o` change by one bit clock. `ws_o`, `sda_o` and `sdb_o` change only on the falling edge of `bclk`.
- R8: The left/right pair captured in input frame N appears in the output frame whose word select falls two bit clocks after input frame N+1 begins. The first output frame after reset carries the pair (0x0000, 0x0000).
- R9: While `rst_n` is low, `sda_o` and `sdb_o` are low.
- R10: In 32-bit input slots, only the first 16 bits after the word-select change form the sample. The remaining bits have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock shared by input and outputs |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_slot_i | input | 1 | Static: 1 selects 32-bit slots, 0 selects 16-bit slots |
| exact_neg_i | input | 1 | Static: 1 selects exact negation, 0 selects bit inversion |
| ws_i | input | 1 | Input word select, low for left |
| sd_i | input | 1 | Input serial data, MSB first |
| ws_o | output | 1 | Regenerated word select for both output streams |
| sda_o | output | 1 | Output stream with the left sample and its inverse |
| sdb_o | output | 1 | Output stream with the right sample and its inverse |

## Verification
The bench builds the block with its default parameters: 16-bit samples and a 7-bit slot counter. This lets it exercise both the 32 bit-clock frame and the 64 bit-clock frame, with all four combinations of slot width and negation method. In each combination it sends zero, plus one, minus one, full-scale positive and the most negative code on both channels, so the saturation case and the sign fill of negative results are reached. In 32-bit slots the padding bits of the input slot are driven with non-zero patterns, to show they are ignored.

// File: rtl/i2s_balanced_split.sv
module i2s_balanced_split #(
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 7
) (
  input  logic bclk,
  input  logic rst_n,
  input  logic wide_slot_i,
  input  logic exact_neg_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic ws_o,
  output logic sda_o,
  output logic sdb_o
);
  localparam int WIDE_W  = 2 * SAMPLE_W;
  localparam int FRAME_W = 2 * WIDE_W;
  localparam logic [SAMPLE_W-1:0] MIN_CODE = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [SAMPLE_W-1:0] MAX_CODE = ~MIN_CODE;
  localparam logic [CNT_W-1:0]    CNT_TOP  = '1;

  logic                ws_q, ws_d2;
  logic [CNT_W-1:0]    cnt_q;
  logic [SAMPLE_W-1:0] shin, left_cap, right_cap;
  logic [FRAME_W-1:0]  sh_a, sh_b;
  logic                sda_pre, sdb_pre;

  function automatic logic [SAMPLE_W-1:0] invert(input logic [SAMPLE_W-1:0] x, input logic exact);
    if (!exact)             return ~x;
    else if (x == MIN_CODE) return MAX_CODE;
    else                    return SAMPLE_W'(~x + 1'b1);
  endfunction

  function automatic logic [WIDE_W-1:0] widen(input logic [SAMPLE_W-1:0] v);
    return {v, {SAMPLE_W{v[SAMPLE_W-1]}}};
  endfunction

  function automatic logic [FRAME_W-1:0] pack(input logic [SAMPLE_W-1:0] p, input logic wide, input logic exact);
    logic [SAMPLE_W-1:0] n;
    n = invert(p, exact);
    if (wide) return {widen(p), widen(n)};
    else      return {p, n, {WIDE_W{1'b0}}};
  endfunction

  wire                ws_edge   = ws_i ^ ws_q;
  wire [CNT_W-1:0]    idx       = ws_edge ? '0 : cnt_q;
  wire [SAMPLE_W-1:0] word_in   = {shin[SAMPLE_W-2:0], sd_i};
  wire                word_done = (cnt_q == CNT_W'(SAMPLE_W));
  wire                load      = !ws_edge && !ws_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge bclk) begin
    ws_q  <= ws_i;
    ws_d2 <= ws_q;
  end

  always_ff @(posedge bclk) begin
    if (!rst_n) begin
      cnt_q     <= CNT_TOP;
      shin      <= '0;
      left_cap  <= '0;
      right_cap <= '0;
      sh_a      <= '0;
      sh_b      <= '0;
      sda_pre   <= 1'b0;
      sdb_pre   <= 1'b0;
    end else begin
      cnt_q <= (idx == CNT_TOP) ? CNT_TOP : idx + 1'b1;
      shin  <= word_in;
      if (word_done) begin
        if (ws_q) right_cap <= word_in;
        else      left_cap  <= word_in;
      end
      sda_pre <= sh_a[FRAME_W-1];
      sdb_pre <= sh_b[FRAME_W-1];
      if (load) begin
        sh_a <= pack(left_cap,  wide_slot_i, exact_neg_i);
        sh_b <= pack(right_cap, wide_slot_i, exact_neg_i);
      end else begin
        sh_a <= sh_a << 1;
        sh_b <= sh_b << 1;
      end
    end
  end

  always_ff @(negedge bclk) begin
    ws_o  <= ws_d2;
    sda_o <= sda_pre;
    sdb_o <= sdb_pre;
  end

  wire [SAMPLE_W-1:0] neg_a = wide_slot_i ? sh_a[WIDE_W-1 -: SAMPLE_W] : sh_a[FRAME_W-SAMPLE_W-1 -: SAMPLE_W];

  p_ws_delay_r7: assert property (@(posedge bclk) disable iff (!rst_n)
    ws_o == $past(ws_i, 2));

  p_pos_copy_r1: assert property (@(posedge bclk) disable iff (!rst_n)
    load |=> (sh_a[FRAME_W-1 -: SAMPLE_W] == $past(left_cap)) && (sh_b[FRAME_W-1 -: SAMPLE_W] == $past(right_cap)));

  p_bitwise_r2: assert property (@(posedge bclk) disable iff (!rst_n)
    (load && !exact_neg_i) |=> neg_a == ~$past(left_cap));

  p_exact_sum_r3: assert property (@(posedge bclk) disable iff (!rst_n)
    (load && exact_neg_i && left_cap != MIN_CODE) |=> SAMPLE_W'(neg_a + sh_a[FRAME_W-1 -: SAMPLE_W]) == '0);

  p_saturate_r4: assert property (@(posedge bclk) disable iff (!rst_n)
    (load && exact_neg_i && left_cap == MIN_CODE) |=> neg_a == MAX_CODE);

  p_sign_fill_r5: assert property (@(posedge bclk) disable iff (!rst_n)
    (load && wide_slot_i) |=> sh_a[FRAME_W-SAMPLE_W-1 -: SAMPLE_W] == {SAMPLE_W{sh_a[FRAME_W-1]}});

  p_quiet_reset_r9: assert property (@(posedge bclk)
    $past(!rst_n) && !rst_n |-> !sda_pre && !sdb_pre);
endmodule

// File: tb/tb_i2s_balanced_split.sv
`timescale 1ns/1ps
module tb_i2s_balanced_split;
  localparam int CLK_PERIOD = 708;
  localparam int HALF = CLK_PERIOD / 2;

  logic bclk = 1'b0, rst_n = 1'b0, wide = 1'b0, exact = 1'b0, ws_i = 1'b1, sd_i = 1'b0;
  logic ws_o, sda_o, sdb_o;

  i2s_balanced_split dut (.bclk(bclk), .rst_n(rst_n), .wide_slot_i(wide), .exact_neg_i(exact),
    .ws_i(ws_i), .sd_i(sd_i), .ws_o(ws_o), .sda_o(sda_o), .sdb_o(sdb_o));

  always #HALF bclk = ~bclk;

  int n_chk = 0, n_fail = 0, slot_w = 16;
  int ws_bad = 0, edge_bad = 0;
  logic carry = 1'b0, done = 1'b0;
  logic [31:0] exp_q[$];

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] ref_neg(logic [15:0] x, logic ex);
    if (!ex) return ~x;
    if (x == 16'h8000) return 16'h7FFF;
    return 16'(16'h0 - x);
  endfunction

  task automatic cmp_stream(string nm, logic [63:0] got, logic [15:0] x);
    logic [15:0] n;
    string tag;
    n = ref_neg(x, exact);
    tag = exact ? ((x == 16'h8000) ? "R4" : "R3") : "R2";
    chk($sformatf("R1 R8 R10 %s positive slot", nm), 64'(got[63:48]), 64'(x));
    chk($sformatf("%s %s inverted slot", tag, nm), 64'(wide ? got[31:16] : got[47:32]), 64'(n));
    if (wide)
      chk($sformatf("R5 %s sign fill", nm), {32'h0, got[47:32], got[15:0]}, {32'h0, {16{x[15]}}, {16{n[15]}}});
  endtask

  // Monitor: collects one output frame per ws_o fall and scores it against the queue.
  initial begin
    int cnt = -1, since = 0;
    logic prev_ws = 1'b1, seen = 1'b0, h1 = 1'b1, h2 = 1'b1;
    logic [63:0] ga = '0, gb = '0;
    logic [31:0] item;
    forever begin
      @(posedge bclk); #1;
      if (!rst_n) begin
        cnt = -1; seen = 1'b0; prev_ws = ws_o;
        h2 = h1; h1 = ws_i;
        continue;
      end
      if (ws_o !== h2) ws_bad++;
      h2 = h1; h1 = ws_i;
      if (cnt >= 0) begin
        ga[63-cnt] = sda_o;
        gb[63-cnt] = sdb_o;
        cnt++;
        if (cnt == 2*slot_w) begin
          if (exp_q.size() > 0) begin
            item = exp_q.pop_front();
            cmp_stream("stream A", ga, item[31:16]);
            cmp_stream("stream B", gb, item[15:0]);
          end
          cnt = -1;
        end
      end
      since++;
      if (prev_ws && !ws_o) begin
        if (seen && exp_q.size() > 0) chk("R6 frame length", 64'(since), 64'(2*slot_w));
        seen = 1'b1; since = 0; cnt = 0; ga = '0; gb = '0;
      end
      prev_ws = ws_o;
    end
  end

  // Outputs must hold across the rising edge (R7: change on falling edge only).
  initial begin
    logic a, b, w;
    forever begin
      @(negedge bclk); #(HALF-1);
      a = sda_o; b = sdb_o; w = ws_o;
      @(posedge bclk); #1;
      if (rst_n && (a !== sda_o || b !== sdb_o || w !== ws_o)) edge_bad++;
    end
  end

  task automatic send_slot(logic ch, logic [15:0] v, logic [15:0] pad);
    logic [31:0] w;
    w = (slot_w == 32) ? {v, pad} : {16'h0, v};
    for (int i = 0; i < slot_w; i++) begin
      @(negedge bclk);
      ws_i = ch;
      sd_i = (i == 0) ? carry : w[slot_w - i];
    end
    carry = w[0];
  endtask

  task automatic send_frame(logic [15:0] l, logic [15:0] r, logic push);
    if (push) exp_q.push_back({l, r});
    send_slot(1'b0, l, 16'hA5F3 ^ l);
    send_slot(1'b1, r, 16'hFFFF);
  endtask

  task automatic run_phase(logic w, logic e);
    logic [15:0] lv[8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h1234, 16'h8001, 16'h0000};
    logic [15:0] rv[8] = '{16'h8000, 16'h7FFF, 16'h0001, 16'hFFFF, 16'h0000, 16'hA5C3, 16'hFFFE, 16'h4321};
    @(negedge bclk);
    rst_n = 1'b0; wide = w; exact = e; ws_i = 1'b1; sd_i = 1'b0; carry = 1'b0;
    slot_w = w ? 32 : 16;
    exp_q.delete();
    repeat (6) @(negedge bclk);
    #1 chk($sformatf("R9 outputs low in reset (wide=%0b exact=%0b)", w, e), {62'h0, sda_o, sdb_o}, 64'h0);
    ws_bad = 0; edge_bad = 0;
    exp_q.push_back(32'h0);  // R8: first output frame holds the cleared pair
    rst_n = 1'b1;
    repeat (4) @(negedge bclk);
    foreach (lv[i]) send_frame(lv[i], rv[i], 1'b1);
    send_frame(16'h0, 16'h0, 1'b0);
    repeat (4*slot_w) begin @(negedge bclk); ws_i = 1'b1; sd_i = 1'b0; end
    chk("R8 every captured pair emitted", 64'(exp_q.size()), 64'h0);
    chk("R7 ws_o is ws_i two edges late", 64'(ws_bad), 64'h0);
    chk("R7 outputs stable across rising edge", 64'(edge_bad), 64'h0);
  endtask

  initial begin
    run_phase(1'b0, 1'b1);
    run_phase(1'b0, 1'b0);
    run_phase(1'b1, 1'b1);
    run_phase(1'b1, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(64'(CLK_PERIOD) * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R8 actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule